// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one vector memory instruction issued by a 64-thread warp. Each thread supplies a byte address and, for stores, up to four bytes of data. An active mask says which threads take part, and one access size applies to all of them. The block folds these per-thread accesses into the fewest cache-line requests it can. Each request names a line and a per-byte mask of the bytes it touches. It also lists the threads it serves. For a store, it carries the bytes to write at their positions within the line.

The block holds one instruction at a time. Once an instruction is taken, the block gives out one request per cycle over a valid/ready handshake. It finishes by pulsing `done`. Any request sent to a cache can then write only the bytes that active threads own. The line size is a parameter and is meant to be set to 64 or 128 bytes. It must be at least the largest access, so that no access covers more than two lines.

Top module: `warp_coalescer`

## Requirements
- R1: While reset is held and in the first cycle after it, `instReady` is 1, and `reqValid` and `done` are 0.
- R2: An instruction is taken at a clock edge where `instValid` and `instReady` are both 1. `instReady` is then 0 until the instruction's `done` cycle. If any thread is active, `reqValid` rises in the first cycle after the instruction is taken. It stays 1 until the last request is accepted.
- R3: An instruction gives out exactly one request for each distinct line its active threads touch. `reqThreads` bit t is 1 when thread t has at least one byte in that line.
- R4: Sixty-four active threads making aligned 4-byte accesses to consecutive words give exactly 4 requests when lines are 64 bytes.
- R5: When every active thread touches a different line, there is one request per active thread.
- R6: Threads whose `instMask` bit is 0 appear in no `reqThreads` field and set no `reqByteMask` bit.
- R7: Requests come out in ascending order of the lowest thread index each one contains.
- R8: An access that runs past the end of a line is split between that line and the next one. The part in the lower-addressed line comes out first.
- R9: `reqByteMask` bit i is 1 exactly when some thread in the request touches byte offset i of the line. For a store, data byte k of a thread lands at byte offset (address + k) mod line size. When several threads write the same byte, the highest-numbered thread's value is used. For loads, `reqData` is all zero, and bytes outside the mask are zero in both cases.
- R10: `instSize` 2'b00 means 1 byte, 2'b01 means 2 bytes, and 2'b10 or 2'b11 means 4 bytes.
- R11: While `reqValid` is 1 and `reqReady` is 0, the request fields do not change in the next cycle, and `reqValid` stays 1.
- R12: `done` is 1 for the single cycle after the edge where the last request is accepted. An instruction with no active thread gives no request, and `done` is 1 in the cycle right after that instruction is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Block is idle and can take an instruction |
| instIsStore | input | 1 | 1 for a store, 0 for a load |
| instSize | input | 2 | Access size code (see R10) |
| instMask | input | THREADS (64) | Active-thread mask |
| instAddr | input | THREADS*ADDR_W (2048) | Byte address of thread t at bits [t*32 +: 32] |
| instData | input | THREADS*DATA_BYTES*8 (2048) | Store data of thread t at bits [t*32 +: 32], byte k at [8k +: 8] |
| reqValid | output | 1 | Request presented |
| reqReady | input | 1 | Downstream accepts the request |
| reqAddr | output | ADDR_W (32) | Byte address of the line start |
| reqByteMask | output | LINE_BYTES (64) | Bytes of the line that the request touches |
| reqThreads | output | THREADS (64) | Threads served by the request |
| reqIsStore | output | 1 | Request is a store |
| reqData | output | LINE_BYTES*8 (512) | Store bytes placed at their line offsets |
| done | output | 1 | One-cycle pulse after the instruction completes |

## Verification
An instruction taken at edge N shows its first request in the cycle after N. Each request accepted at edge M is replaced by the next one in the cycle after M. `done` rises one cycle after the final handshake, or one cycle after acceptance when no thread is active. The bench drives all inputs just after the falling edge and samples all outputs there. In the same step it updates its own queue of expected requests, using only the inputs it has just committed for the coming rising edge. As a result, each comparison lands exactly one register stage after the stimulus that causes it. The bench also holds `reqReady` low on pseudo-random cycles, so stalled requests are compared again on the following cycles.

// File: rtl/wc_pkg.sv
package wc_pkg;

  // strobes from the sequencing FSM to the datapath
  typedef struct packed {
    logic load;     // capture a new instruction
    logic advance;  // current request accepted, retire its segments
  } wcCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } wcState_t;

  // size code to byte count: 0 -> 1, 1 -> 2, others -> 4
  function automatic logic [2:0] sizeToBytes(input logic [1:0] code);
    case (code)
      2'b00:   sizeToBytes = 3'd1;
      2'b01:   sizeToBytes = 3'd2;
      default: sizeToBytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/wc_datapath.sv
module wc_datapath
  import wc_pkg::*;
#(
  parameter int THREADS    = 64,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  wcCtrl_t                        ctrl,
  input  logic                           instIsStore,
  input  logic [1:0]                     instSize,
  input  logic [THREADS-1:0]             instMask,
  input  logic [THREADS*ADDR_W-1:0]      instAddr,
  input  logic [THREADS*DATA_BYTES*8-1:0] instData,
  output logic                           anyPending,
  output logic                           lastReq,
  output logic                           loadEmpty,
  output logic [ADDR_W-1:0]              reqAddr,
  output logic [LINE_BYTES-1:0]          reqByteMask,
  output logic [THREADS-1:0]             reqThreads,
  output logic                           reqIsStore,
  output logic [LINE_BYTES*8-1:0]        reqData
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int TID_W  = $clog2(THREADS);
  localparam int DW     = DATA_BYTES * 8;

  // captured instruction
  logic [ADDR_W-1:0] addrQ [THREADS];
  logic [DW-1:0]     dataQ [THREADS];
  logic [1:0]        sizeQ;
  logic              storeQ;
  logic [2:0]        nBytesQ;
  logic [2:0]        nBytesIn;

  // one pending bit per segment: start line and (if crossing) following line
  logic [THREADS-1:0] pendLo, pendHi;
  logic [THREADS-1:0] crossIn;

  logic [LINE_W-1:0] loLine [THREADS];
  logic [LINE_W-1:0] hiLine [THREADS];
  logic [THREADS-1:0] hitLo, hitHi, hitAny;

  logic [TID_W-1:0]  leadIdx;
  logic [LINE_W-1:0] leadLine;

  assign nBytesQ  = sizeToBytes(sizeQ);
  assign nBytesIn = sizeToBytes(instSize);

  // per-thread line extraction and match against the chosen line
  genvar gt;
  generate
    for (gt = 0; gt < THREADS; gt++) begin : g_thr
      logic [ADDR_W-1:0] endQ;
      logic [ADDR_W-1:0] inStart;
      logic [ADDR_W-1:0] inEnd;

      assign endQ        = addrQ[gt] + ADDR_W'(nBytesQ) - ADDR_W'(1);
      assign loLine[gt]  = addrQ[gt][ADDR_W-1:OFF_W];
      assign hiLine[gt]  = endQ[ADDR_W-1:OFF_W];
      assign hitLo[gt]   = pendLo[gt] && (loLine[gt] == leadLine);
      assign hitHi[gt]   = pendHi[gt] && (hiLine[gt] == leadLine);
      assign hitAny[gt]  = hitLo[gt] || hitHi[gt];

      assign inStart     = instAddr[gt*ADDR_W +: ADDR_W];
      assign inEnd       = inStart + ADDR_W'(nBytesIn) - ADDR_W'(1);
      assign crossIn[gt] = instMask[gt] &&
                           (inStart[ADDR_W-1:OFF_W] != inEnd[ADDR_W-1:OFF_W]);
    end
  endgenerate

  // leader: lowest-numbered thread that still owns a pending segment
  always_comb begin
    leadIdx = '0;
    for (int t = THREADS - 1; t >= 0; t--) begin
      if (pendLo[t] || pendHi[t]) leadIdx = TID_W'(t);
    end
    leadLine = pendLo[leadIdx] ? loLine[leadIdx] : hiLine[leadIdx];
  end

  // byte placement; ascending thread loop so the highest thread wins a byte
  always_comb begin
    logic [ADDR_W-1:0] byteA;
    logic [OFF_W-1:0]  off;
    reqByteMask = '0;
    reqData     = '0;
    byteA       = '0;
    off         = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (hitAny[t]) begin
        for (int k = 0; k < DATA_BYTES; k++) begin
          if (k < int'(nBytesQ)) begin
            byteA = addrQ[t] + ADDR_W'(k);
            off   = byteA[OFF_W-1:0];
            if (byteA[ADDR_W-1:OFF_W] == leadLine) begin
              reqByteMask[off] = 1'b1;
              if (storeQ) reqData[int'(off)*8 +: 8] = dataQ[t][k*8 +: 8];
            end
          end
        end
      end
    end
  end

  assign reqThreads = hitAny;
  assign reqAddr    = {leadLine, {OFF_W{1'b0}}};
  assign reqIsStore = storeQ;
  assign anyPending = |(pendLo | pendHi);
  assign lastReq    = ~|((pendLo & ~hitLo) | (pendHi & ~hitHi));
  assign loadEmpty  = ~|instMask;

  // pending segment bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendLo <= '0;
      pendHi <= '0;
    end else if (ctrl.load) begin
      pendLo <= instMask;
      pendHi <= crossIn;
    end else if (ctrl.advance) begin
      pendLo <= pendLo & ~hitLo;
      pendHi <= pendHi & ~hitHi;
    end
  end

  // payload capture, no reset needed
  always_ff @(posedge clk) begin
    if (ctrl.load) begin
      sizeQ  <= instSize;
      storeQ <= instIsStore;
      for (int t = 0; t < THREADS; t++) begin
        addrQ[t] <= instAddr[t*ADDR_W +: ADDR_W];
        dataQ[t] <= instData[t*DW +: DW];
      end
    end
  end

  // R11: request fields hold while nothing is accepted
  assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (anyPending && !ctrl.advance && !ctrl.load) |=>
      ($stable(reqAddr) && $stable(reqByteMask) && $stable(reqThreads) && $stable(reqData)));

  // R9, R3: a live request always touches at least one byte and one thread
  assert_req_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    anyPending |-> ((reqByteMask != '0) && (reqThreads != '0)));

  // R6: freshly loaded work only covers active threads
  assert_load_active_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> (((pendLo | pendHi) & ~$past(instMask)) == '0));

  // R3: pending work never grows outside a load
  assert_pending_shrinks_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> (((pendLo & ~$past(pendLo)) | (pendHi & ~$past(pendHi))) == '0));

  // R3: an accepted request retires at least one segment
  assert_progress_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |=> ($countones(pendLo | pendHi) < $countones($past(pendLo | pendHi))
                      || $countones(pendHi) < $countones($past(pendHi))
                      || $countones(pendLo) < $countones($past(pendLo))));

endmodule

// File: rtl/wc_control.sv
module wc_control
  import wc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    instValid,
  input  logic    reqReady,
  input  logic    anyPending,
  input  logic    lastReq,
  input  logic    loadEmpty,
  output wcCtrl_t ctrl,
  output logic    instReady,
  output logic    reqValid,
  output logic    done
);

  wcState_t state;
  logic     doneQ;

  assign instReady    = (state == ST_IDLE);
  assign reqValid     = (state == ST_BUSY) && anyPending;
  assign ctrl.load    = instValid && instReady;
  assign ctrl.advance = reqValid && reqReady;
  assign done         = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctrl.load) begin
            if (loadEmpty) doneQ <= 1'b1;
            else           state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (ctrl.advance && lastReq) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: while busy the datapath always has a request to offer
  assert_busy_has_work_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSY) |-> anyPending);

  // R11: a stalled request is still offered next cycle
  assert_stall_keeps_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> reqValid);

  // R12: completion pulse only in the idle state, after the last acceptance
  assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (instReady && !reqValid));

  assert_done_after_last_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && lastReq) |=> done);

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import wc_pkg::*;
#(
  parameter int THREADS    = 64,
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            instValid,
  output logic                            instReady,
  input  logic                            instIsStore,
  input  logic [1:0]                      instSize,
  input  logic [THREADS-1:0]              instMask,
  input  logic [THREADS*ADDR_W-1:0]       instAddr,
  input  logic [THREADS*DATA_BYTES*8-1:0] instData,
  output logic                            reqValid,
  input  logic                            reqReady,
  output logic [ADDR_W-1:0]               reqAddr,
  output logic [LINE_BYTES-1:0]           reqByteMask,
  output logic [THREADS-1:0]              reqThreads,
  output logic                            reqIsStore,
  output logic [LINE_BYTES*8-1:0]         reqData,
  output logic                            done
);

  wcCtrl_t ctrl;
  logic    anyPending;
  logic    lastReq;
  logic    loadEmpty;

  wc_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .instValid  (instValid),
    .reqReady   (reqReady),
    .anyPending (anyPending),
    .lastReq    (lastReq),
    .loadEmpty  (loadEmpty),
    .ctrl       (ctrl),
    .instReady  (instReady),
    .reqValid   (reqValid),
    .done       (done)
  );

  wc_datapath #(
    .THREADS    (THREADS),
    .ADDR_W     (ADDR_W),
    .DATA_BYTES (DATA_BYTES),
    .LINE_BYTES (LINE_BYTES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .instIsStore (instIsStore),
    .instSize    (instSize),
    .instMask    (instMask),
    .instAddr    (instAddr),
    .instData    (instData),
    .anyPending  (anyPending),
    .lastReq     (lastReq),
    .loadEmpty   (loadEmpty),
    .reqAddr     (reqAddr),
    .reqByteMask (reqByteMask),
    .reqThreads  (reqThreads),
    .reqIsStore  (reqIsStore),
    .reqData     (reqData)
  );

endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;

  localparam int TH = 64;
  localparam int AW = 32;
  localparam int DB = 4;
  localparam int LB = 64;
  localparam int OW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rstN;
  logic               instValid, instReady, instIsStore;
  logic [1:0]         instSize;
  logic [TH-1:0]      instMask;
  logic [TH*AW-1:0]   instAddr;
  logic [TH*DB*8-1:0] instData;
  logic               reqValid, reqReady, reqIsStore, done;
  logic [AW-1:0]      reqAddr;
  logic [LB-1:0]      reqByteMask;
  logic [TH-1:0]      reqThreads;
  logic [LB*8-1:0]    reqData;

  warp_coalescer u_dut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instReady(instReady),
    .instIsStore(instIsStore), .instSize(instSize), .instMask(instMask),
    .instAddr(instAddr), .instData(instData), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqByteMask(reqByteMask),
    .reqThreads(reqThreads), .reqIsStore(reqIsStore), .reqData(reqData),
    .done(done)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // expected request stream
  logic [AW-1:0]   qLine[$];
  logic [TH-1:0]   qThr[$];
  logic [LB-1:0]   qMask[$];
  logic [LB*8-1:0] qData[$];

  logic [AW-1:0] tAddr [TH];
  logic [31:0]   tData [TH];
  bit expBusy = 0, expDone = 0, issuePending = 0, prevStall = 0;
  int reqCount = 0;
  logic [TH-1:0] curMask;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [LB*8-1:0] act, input logic [LB*8-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // behavioural model: lines in order of first touch by (thread, byte)
  task automatic buildExp();
    int n;
    n = (instSize == 2'b00) ? 1 : (instSize == 2'b01) ? 2 : 4;
    for (int t = 0; t < TH; t++) begin
      if (curMask[t]) begin
        for (int k = 0; k < n; k++) begin
          logic [AW-1:0]   a, ln;
          logic [TH-1:0]   tt;
          logic [LB-1:0]   mm;
          logic [LB*8-1:0] dd;
          int idx;
          a = tAddr[t] + AW'(k);
          ln = {a[AW-1:OW], {OW{1'b0}}};
          idx = -1;
          for (int i = 0; i < qLine.size(); i++) if (qLine[i] == ln) idx = i;
          if (idx < 0) begin
            qLine.push_back(ln); qThr.push_back('0); qMask.push_back('0); qData.push_back('0);
            idx = qLine.size() - 1;
          end
          tt = qThr[idx]; tt[t] = 1'b1; qThr[idx] = tt;
          mm = qMask[idx]; mm[a[OW-1:0]] = 1'b1; qMask[idx] = mm;
          if (instIsStore) begin
            dd = qData[idx]; dd[int'(a[OW-1:0])*8 +: 8] = tData[t][k*8 +: 8]; qData[idx] = dd;
          end
        end
      end
    end
  endtask

  task automatic step();
    bit busyNow;
    @(negedge clk);
    chk(instReady == !expBusy, "R2", "instReady", LB*8'(instReady), LB*8'(!expBusy));
    chk(reqValid == (expBusy && qLine.size() > 0), "R2", "reqValid",
        LB*8'(reqValid), LB*8'(expBusy && qLine.size() > 0));
    chk(done == expDone, "R12", "done", LB*8'(done), LB*8'(expDone));
    if (reqValid && qLine.size() > 0) begin
      chk(reqAddr == qLine[0], prevStall ? "R11" : "R7", "reqAddr", LB*8'(reqAddr), LB*8'(qLine[0]));
      chk(reqThreads == qThr[0], "R3", "reqThreads", LB*8'(reqThreads), LB*8'(qThr[0]));
      chk((reqThreads & ~curMask) == '0, "R6", "inactive threads", LB*8'(reqThreads), LB*8'(reqThreads & curMask));
      chk(reqByteMask == qMask[0], "R9", "reqByteMask", LB*8'(reqByteMask), LB*8'(qMask[0]));
      chk(reqData == qData[0], "R9", "reqData", reqData, qData[0]);
    end
    busyNow = expBusy;
    expDone = 0;
    instValid = 1'b0;
    reqReady = ($urandom_range(3) != 0);
    prevStall = 0;
    if (busyNow && qLine.size() > 0) begin
      if (reqReady) begin
        void'(qLine.pop_front()); void'(qThr.pop_front());
        void'(qMask.pop_front()); void'(qData.pop_front());
        reqCount++;
        if (qLine.size() == 0) begin expBusy = 0; expDone = 1; end
      end else begin
        prevStall = 1;
      end
    end
    if (issuePending && !busyNow) begin
      instValid = 1'b1;
      issuePending = 0;
      buildExp();
      if (qLine.size() == 0) expDone = 1;
      else expBusy = 1;
    end
  endtask

  task automatic runInst(input logic st, input logic [1:0] sz, input logic [TH-1:0] m,
                         input int expCount, input string tag);
    instIsStore = st;
    instSize = sz;
    instMask = m;
    curMask = m;
    for (int t = 0; t < TH; t++) begin
      instAddr[t*AW +: AW] = tAddr[t];
      instData[t*32 +: 32] = tData[t];
    end
    reqCount = 0;
    issuePending = 1;
    while (issuePending || expBusy) step();
    step();
    chk(reqCount == expCount, tag, "request count", LB*8'(reqCount), LB*8'(expCount));
  endtask

  initial begin
    rstN = 1'b0; instValid = 1'b0; reqReady = 1'b0; instIsStore = 1'b0;
    instSize = 2'b10; instMask = '0; instAddr = '0; instData = '0; curMask = '0;
    for (int t = 0; t < TH; t++) begin
      tData[t] = {8'(t), 8'(t + 1) ^ 8'hC3, 8'(3 * t), 8'hA5 ^ 8'(t)};
      tAddr[t] = '0;
    end
    repeat (3) @(negedge clk);
    chk(instReady == 1'b1 && reqValid == 1'b0 && done == 1'b0, "R1", "in reset",
        LB*8'({instReady, reqValid, done}), LB*8'(3'b100));
    rstN = 1'b1;
    @(negedge clk);
    chk(instReady == 1'b1 && reqValid == 1'b0 && done == 1'b0, "R1", "after reset",
        LB*8'({instReady, reqValid, done}), LB*8'(3'b100));

    // R4: consecutive aligned words, full warp
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h1000 + 32'(4 * t);
    runInst(1'b1, 2'b10, {TH{1'b1}}, 4, "R4");

    // R6: same pattern, partial mask
    runInst(1'b1, 2'b10, 64'h00FF_00FF_00FF_00FF, 4, "R6");

    // R5: scattered, every fourth thread active
    for (int t = 0; t < TH; t++) tAddr[t] = 32'(t) * 32'h1000 + 32'(8 * t);
    runInst(1'b0, 2'b10, 64'h1111_1111_1111_1111, 16, "R5");

    // R8: each access crosses a line boundary
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h2000 + 32'(128 * t) + 32'd62;
    runInst(1'b1, 2'b10, 64'h0000_0000_0000_00FF, 16, "R8");
    runInst(1'b1, 2'b11, 64'h8000_0000_0000_0001, 4, "R10");

    // R10: byte and halfword sizes
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h3000 + 32'(t);
    runInst(1'b1, 2'b00, {TH{1'b1}}, 1, "R10");
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h3000 + 32'(2 * t);
    runInst(1'b1, 2'b01, {TH{1'b1}}, 2, "R10");

    // R9: all threads store to one word, highest thread wins
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h4004;
    runInst(1'b1, 2'b10, {TH{1'b1}}, 1, "R9");

    // R12: no active thread
    runInst(1'b1, 2'b10, '0, 0, "R12");

    // R7: descending lines against ascending threads
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h8000 + 32'(64 * (TH - 1 - t));
    runInst(1'b0, 2'b10, {TH{1'b1}}, 64, "R7");

    // R3: threads interleaved over two lines, load
    for (int t = 0; t < TH; t++) tAddr[t] = 32'h9000 + 32'((t % 2) * 64) + 32'(t / 2);
    runInst(1'b0, 2'b00, {TH{1'b1}}, 2, "R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule